// File: doc/BRIEF.md
# Low-Voltage SRAM Access Sequencer

This block turns single-port memory requests into the slow, phase-by-phase control strobes of a banked SRAM array. Each bitcell in the array has separate read and write ports. A request carries a valid flag, a write flag, an 11-bit address and a 128-bit write word. The sequencer decodes the address into a one-hot block select and a one-hot global row line. It then steps through a fixed order of phases. Each phase lasts a number of clock cycles set by a parameter, so the array has time to settle at very low supply voltages.

A write first enables the write drivers, which put the new word on the differential write bitlines. After that the global and local write wordlines rise. While the wordline is high, the supply header of the addressed row is switched off so that the row's virtual rail floats and the cells can flip. The header is switched back on while the wordline is still high, and the wordline falls only after the rail has reconnected. A read first precharges the block's single-ended read bitline. It then raises the separate read wordline and captures the settled bitline level as the returned word, which is presented together with a one-cycle valid pulse.

The sequencer handles one request at a time. Its ready output stays low from the cycle a request is accepted until its sequence has finished.

Top module: `lvSramSeq`

## Requirements
- R1: While reset is held and just after it is released, reqReady is 1, rdValid is 0, and every array strobe, write bitline, wordline, header-off and precharge output is 0.
- R2: Address bits [10:8] choose the block and bits [7:0] choose the row. While a wordline phase is active, blkSel is one-hot at the block index and gwl is one-hot at the row index. Outside wordline phases both are all zero.
- R3: A local write or read wordline bit for block b is 1 only while blkSel[b] is 1 and a global row line is active.
- R4: A write holds wrDrvEn at 1, wrBl equal to the write word and wrBlb equal to its inverse for SETUP cycles before the local write wordline rises. The drivers stay on until the wordline falls.
- R5: After the local write wordline has been high for WLON cycles, the header of the addressed row (hdrOff of that block) is 1 for exactly FLOAT cycles. The wordline stays high throughout.
- R6: After the float phase, the header is on again for RESTORE cycles with the local write wordline still at 1. Only then do the wordline and the global row line fall.
- R7: When no write is in progress, wrDrvEn is 0 and wrBl and wrBlb are both all zero.
- R8: A read asserts rblPrechg for the addressed block for PRE cycles with no read wordline. It then asserts the local read wordline for EVAL cycles with precharge off. The two never overlap.
- R9: hdrOff stays all zero during idle and during every phase of a read.
- R10: The read bitline level on the last evaluate cycle appears on rdData in the next cycle, with rdValid high for exactly that one cycle.
- R11: reqReady is 0 from the cycle after a request is accepted until its sequence ends. Requests presented while reqReady is 0 have no effect on the array.
- R12: A read of an address returns the word most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | [10:8] block, [7:0] row |
| reqWdata | input | 128 | Word to write |
| reqReady | output | 1 | Sequencer idle, request accepted when valid |
| rdValid | output | 1 | One-cycle pulse marking rdData |
| rdData | output | 128 | Captured read word |
| wrDrvEn | output | 1 | Write drivers enabled |
| wrBl | output | 128 | True write bitlines (0 when drivers off) |
| wrBlb | output | 128 | Complement write bitlines (0 when drivers off) |
| gwl | output | 256 | One-hot global row line |
| blkSel | output | 8 | One-hot block select |
| lwwl | output | 8 | Local write wordline per block |
| lrwl | output | 8 | Local read wordline per block |
| hdrOff | output | 8 | Supply header of addressed row switched off, per block |
| rblPrechg | output | 8 | Read bitline precharge per block |
| senseCap | output | 1 | Capture strobe on last evaluate cycle |
| rblData | input | 128 | Sensed read bitline levels from the array |

## Verification
The hardest case to reach is a request that arrives while a sequence is in flight. It must leave no trace, and that can be seen only by reading the targeted address afterwards and finding its old contents. Directed cases therefore hold a conflicting write or read valid through every busy cycle of an operation, and then read back the addresses those requests targeted. Random traffic draws addresses from a small pool that includes the lowest and highest rows and blocks, so most reads hit addresses that were written earlier. A behavioural array in the bench commits data only while the header is off with the wordline up, so any shortened or misordered float phase shows up in the returned words.

// File: rtl/lvSramPkg.sv
package lvSramPkg;

  typedef struct packed {
    logic load;    // capture request into datapath
    logic drvEn;   // write drivers on
    logic wlOn;    // global row line and block select active
    logic wwl;     // local write wordline
    logic rwl;     // local read wordline
    logic hdrOff;  // row supply header off (rail floats)
    logic prechg;  // read bitline precharge
    logic sense;   // capture read bitline
  } strobes_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_W_SETUP,
    PH_W_WLON,
    PH_W_FLOAT,
    PH_W_REST,
    PH_R_PRE,
    PH_R_EVAL
  } phase_e;

endpackage

// File: rtl/lvSramCtrl.sv
module lvSramCtrl
  import lvSramPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int T_SETUP   = 2,
  parameter int T_WLON    = 2,
  parameter int T_FLOAT   = 3,
  parameter int T_RESTORE = 2,
  parameter int T_PRE     = 2,
  parameter int T_EVAL    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output strobes_t strb
);

  localparam logic [CNT_W-1:0] LD_SETUP   = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_WLON    = CNT_W'(T_WLON - 1);
  localparam logic [CNT_W-1:0] LD_FLOAT   = CNT_W'(T_FLOAT - 1);
  localparam logic [CNT_W-1:0] LD_RESTORE = CNT_W'(T_RESTORE - 1);
  localparam logic [CNT_W-1:0] LD_PRE     = CNT_W'(T_PRE - 1);
  localparam logic [CNT_W-1:0] LD_EVAL    = CNT_W'(T_EVAL - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             go, lastCycle;

  assign go        = reqValid && (phase == PH_IDLE);
  assign lastCycle = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    if (phase == PH_IDLE) begin
      if (go) begin
        phaseNext = reqWrite ? PH_W_SETUP : PH_R_PRE;
        cntNext   = reqWrite ? LD_SETUP : LD_PRE;
      end
    end else if (!lastCycle) begin
      cntNext = cnt - 1'b1;
    end else begin
      unique case (phase)
        PH_W_SETUP: begin phaseNext = PH_W_WLON;  cntNext = LD_WLON;    end
        PH_W_WLON:  begin phaseNext = PH_W_FLOAT; cntNext = LD_FLOAT;   end
        PH_W_FLOAT: begin phaseNext = PH_W_REST;  cntNext = LD_RESTORE; end
        PH_R_PRE:   begin phaseNext = PH_R_EVAL;  cntNext = LD_EVAL;    end
        default:    begin phaseNext = PH_IDLE;    cntNext = '0;         end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strb      = '0;
    strb.load = go;
    unique case (phase)
      PH_W_SETUP: strb.drvEn = 1'b1;
      PH_W_WLON: begin
        strb.drvEn = 1'b1; strb.wlOn = 1'b1; strb.wwl = 1'b1;
      end
      PH_W_FLOAT: begin
        strb.drvEn = 1'b1; strb.wlOn = 1'b1; strb.wwl = 1'b1; strb.hdrOff = 1'b1;
      end
      PH_W_REST: begin
        strb.drvEn = 1'b1; strb.wlOn = 1'b1; strb.wwl = 1'b1;
      end
      PH_R_PRE:  strb.prechg = 1'b1;
      PH_R_EVAL: begin
        strb.wlOn = 1'b1; strb.rwl = 1'b1; strb.sense = lastCycle;
      end
      default: ;
    endcase
  end

  assign reqReady = (phase == PH_IDLE);

endmodule

// File: rtl/lvSramDatapath.sv
module lvSramDatapath
  import lvSramPkg::*;
#(
  parameter  int DATA_W = 128,
  parameter  int BLOCKS = 8,
  parameter  int ROWS   = 256,
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = BLK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rblData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              wrDrvEn,
  output logic [DATA_W-1:0] wrBl,
  output logic [DATA_W-1:0] wrBlb,
  output logic [ROWS-1:0]   gwl,
  output logic [BLOCKS-1:0] blkSel,
  output logic [BLOCKS-1:0] lwwl,
  output logic [BLOCKS-1:0] lrwl,
  output logic [BLOCKS-1:0] hdrOff,
  output logic [BLOCKS-1:0] rblPrechg,
  output logic              senseCap
);

  logic [BLK_W-1:0]  blkReg;
  logic [ROW_W-1:0]  rowReg;
  logic [DATA_W-1:0] dataReg;
  logic [BLOCKS-1:0] blkDec;
  logic              rowActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkReg  <= '0;
      rowReg  <= '0;
      dataReg <= '0;
    end else if (strb.load) begin
      blkReg  <= reqAddr[ADDR_W-1:ROW_W];
      rowReg  <= reqAddr[ROW_W-1:0];
      dataReg <= reqWdata;
    end
  end

  assign blkDec    = BLOCKS'(1) << blkReg;
  assign gwl       = strb.wlOn ? (ROWS'(1) << rowReg) : '0;
  assign rowActive = |gwl;

  // local wordlines combine the global row line with the block select
  for (genvar b = 0; b < BLOCKS; b++) begin : gBlk
    assign blkSel[b]    = strb.wlOn & blkDec[b];
    assign lwwl[b]      = strb.wwl & blkSel[b] & rowActive;
    assign lrwl[b]      = strb.rwl & blkSel[b] & rowActive;
    assign hdrOff[b]    = strb.hdrOff & lwwl[b];
    assign rblPrechg[b] = strb.prechg & blkDec[b];
  end

  assign wrDrvEn  = strb.drvEn;
  assign wrBl     = strb.drvEn ? dataReg : '0;
  assign wrBlb    = strb.drvEn ? ~dataReg : '0;
  assign senseCap = strb.sense;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.sense;
      if (strb.sense) rdData <= rblData;
    end
  end

endmodule

// File: rtl/lvSramSeq.sv
module lvSramSeq
  import lvSramPkg::*;
#(
  parameter  int DATA_W    = 128,
  parameter  int BLOCKS    = 8,
  parameter  int ROWS      = 256,
  parameter  int CNT_W     = 8,
  parameter  int T_SETUP   = 2,
  parameter  int T_WLON    = 2,
  parameter  int T_FLOAT   = 3,
  parameter  int T_RESTORE = 2,
  parameter  int T_PRE     = 2,
  parameter  int T_EVAL    = 3,
  localparam int ADDR_W    = $clog2(BLOCKS) + $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              wrDrvEn,
  output logic [DATA_W-1:0] wrBl,
  output logic [DATA_W-1:0] wrBlb,
  output logic [ROWS-1:0]   gwl,
  output logic [BLOCKS-1:0] blkSel,
  output logic [BLOCKS-1:0] lwwl,
  output logic [BLOCKS-1:0] lrwl,
  output logic [BLOCKS-1:0] hdrOff,
  output logic [BLOCKS-1:0] rblPrechg,
  output logic              senseCap,
  input  logic [DATA_W-1:0] rblData
);

  strobes_t strb;

  lvSramCtrl #(
    .CNT_W(CNT_W), .T_SETUP(T_SETUP), .T_WLON(T_WLON), .T_FLOAT(T_FLOAT),
    .T_RESTORE(T_RESTORE), .T_PRE(T_PRE), .T_EVAL(T_EVAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  lvSramDatapath #(.DATA_W(DATA_W), .BLOCKS(BLOCKS), .ROWS(ROWS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rblData(rblData), .rdValid(rdValid), .rdData(rdData), .wrDrvEn(wrDrvEn),
    .wrBl(wrBl), .wrBlb(wrBlb), .gwl(gwl), .blkSel(blkSel), .lwwl(lwwl),
    .lrwl(lrwl), .hdrOff(hdrOff), .rblPrechg(rblPrechg), .senseCap(senseCap)
  );

endmodule

// File: rtl/lvSramSeqChk.sv
module lvSramSeqChk #(
  parameter int BLOCKS = 8,
  parameter int ROWS   = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic              wrDrvEn,
  input logic [ROWS-1:0]   gwl,
  input logic [BLOCKS-1:0] blkSel,
  input logic [BLOCKS-1:0] lwwl,
  input logic [BLOCKS-1:0] lrwl,
  input logic [BLOCKS-1:0] hdrOff,
  input logic [BLOCKS-1:0] rblPrechg
);

  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blkSel) && $onehot0(gwl));

  a_r3_local_needs_global: assert property (@(posedge clk) disable iff (!rstN)
    ((lwwl | lrwl) != '0) |-> (((lwwl | lrwl) & ~blkSel) == '0) && (gwl != '0));

  a_r4_drive_before_wl: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|lwwl) |-> $past(wrDrvEn));

  a_r5_float_after_wl: assert property (@(posedge clk) disable iff (!rstN)
    (|hdrOff) |-> $past(|lwwl));

  a_r6_rail_back_before_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|lwwl) |-> !$past(|hdrOff));

  a_r7_drivers_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !wrDrvEn);

  a_r8_no_prechg_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (|rblPrechg) |-> (lrwl == '0));

  a_r9_header_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (|lrwl) |-> (hdrOff == '0));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

bind lvSramSeq lvSramSeqChk #(.BLOCKS(BLOCKS), .ROWS(ROWS)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .wrDrvEn(wrDrvEn), .gwl(gwl), .blkSel(blkSel), .lwwl(lwwl), .lrwl(lrwl),
  .hdrOff(hdrOff), .rblPrechg(rblPrechg)
);

// File: tb/tb_lvSramSeq.sv
module tb_lvSramSeq;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 128, NB = 8, NR = 256, AW = 11;
  localparam int S = 2, W = 2, F = 3, RS = 2, P = 2, E = 3;
  localparam int WTOT = S + W + F + RS;
  localparam int RTOT = P + E;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rdValid, wrDrvEn, senseCap;
  logic [DW-1:0] rdData, wrBl, wrBlb, rblData;
  logic [NR-1:0] gwl;
  logic [NB-1:0] blkSel, lwwl, lrwl, hdrOff, rblPrechg;

  logic [DW-1:0] arr [NB*NR];
  logic [DW-1:0] shadow [NB*NR];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvSramSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdValid(rdValid), .rdData(rdData), .wrDrvEn(wrDrvEn), .wrBl(wrBl),
    .wrBlb(wrBlb), .gwl(gwl), .blkSel(blkSel), .lwwl(lwwl), .lrwl(lrwl),
    .hdrOff(hdrOff), .rblPrechg(rblPrechg), .senseCap(senseCap), .rblData(rblData)
  );

  function automatic int arrIdx(logic [NR-1:0] g, logic [NB-1:0] b);
    int r = 0, k = 0;
    for (int i = 0; i < NR; i++) if (g[i]) r = i;
    for (int i = 0; i < NB; i++) if (b[i]) k = i;
    return k * NR + r;
  endfunction

  // behavioural array: cells flip only while the rail floats under a raised wordline
  always @(posedge clk)
    if ((lwwl & hdrOff) != '0) arr[arrIdx(gwl, blkSel)] <= wrBl;

  always_comb rblData = (lrwl != '0) ? arr[arrIdx(gwl, blkSel)] : '1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp<=200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // write with optional conflicting request held during the busy cycles
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit junk, input logic [AW-1:0] ja, input logic [DW-1:0] jd);
    logic [NR-1:0] rowBit = NR'(1) << a[7:0];
    logic [NB-1:0] blkBit = NB'(1) << a[10:8];
    @(negedge clk);
    chk(reqReady, "R11 ready before write", DW'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(posedge clk);
    for (int i = 0; i <= WTOT; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (junk) begin reqAddr = ja; reqWdata = jd; reqWrite = 1'b1; end
        else reqValid = 1'b0;
      end
      if (i == WTOT - 1) reqValid = 1'b0;
      if (i < WTOT) begin
        logic inWl = (i >= S);
        logic inFl = (i >= S + W) && (i < S + W + F);
        chk(!reqReady, "R11 busy", DW'(reqReady), 0);
        chk(wrDrvEn && wrBl == d && wrBlb == ~d, "R4 drivers", wrBlb, ~d);
        chk(gwl == (inWl ? rowBit : '0) && blkSel == (inWl ? blkBit : '0),
            "R2 decode", DW'(blkSel), DW'(inWl ? blkBit : '0));
        chk(lwwl == (inWl ? blkBit : '0) && lrwl == '0, "R3 R6 write wordline",
            DW'(lwwl), DW'(inWl ? blkBit : '0));
        chk(hdrOff == (inFl ? blkBit : '0), "R5 header float", DW'(hdrOff),
            DW'(inFl ? blkBit : '0));
      end else begin
        chk(reqReady, "R11 ready after write", DW'(reqReady), 1);
        chk(!wrDrvEn && wrBl == '0 && wrBlb == '0, "R7 drivers off", wrBlb, '0);
        chk(lwwl == '0 && hdrOff == '0 && gwl == '0, "R6 wordline dropped",
            DW'(lwwl), 0);
      end
    end
    shadow[a] = d;
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit junk, input logic [AW-1:0] ja);
    logic [NR-1:0] rowBit = NR'(1) << a[7:0];
    logic [NB-1:0] blkBit = NB'(1) << a[10:8];
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(posedge clk);
    for (int i = 0; i <= RTOT + 1; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (junk) begin reqAddr = ja; reqWrite = 1'b1; reqWdata = '1; end
        else reqValid = 1'b0;
      end
      if (i == RTOT - 1) reqValid = 1'b0;
      if (i < P) begin
        chk(rblPrechg == blkBit && lrwl == '0 && gwl == '0, "R8 precharge",
            DW'(rblPrechg), DW'(blkBit));
      end else if (i < RTOT) begin
        chk(rblPrechg == '0 && lrwl == blkBit && gwl == rowBit, "R8 R2 evaluate",
            DW'(lrwl), DW'(blkBit));
        chk(!reqReady, "R11 busy read", DW'(reqReady), 0);
      end else if (i == RTOT) begin
        chk(rdValid, "R10 valid pulse", DW'(rdValid), 1);
        chk(rdData == shadow[a], "R12 R10 read data", rdData, shadow[a]);
        chk(reqReady, "R11 ready after read", DW'(reqReady), 1);
      end else begin
        chk(!rdValid, "R10 single pulse", DW'(rdValid), 0);
      end
      chk(hdrOff == '0 && !wrDrvEn && wrBl == '0, "R9 R7 read leaves rail and drivers",
          DW'(hdrOff), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < NB * NR; i++) begin arr[i] = '0; shadow[i] = '0; end
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(reqReady && !rdValid && !wrDrvEn && gwl == '0 && lwwl == '0 && lrwl == '0 &&
        hdrOff == '0 && rblPrechg == '0 && wrBl == '0 && wrBlb == '0 && !senseCap,
        "R1 reset state", DW'({reqReady, rdValid, wrDrvEn}), DW'(3'b100));
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rdValid && gwl == '0, "R1 after release", DW'(reqReady), 1);

    // directed corners
    doRead(11'h000, 1'b0, '0);                                   // R12 unwritten = 0
    doWrite(11'h000, {4{32'hA5A5_5A5A}}, 1'b0, '0, '0);
    doWrite(11'h7FF, '1, 1'b0, '0, '0);
    doRead(11'h000, 1'b0, '0);
    doRead(11'h7FF, 1'b0, '0);
    doWrite(11'h7FF, '0, 1'b0, '0, '0);
    doRead(11'h7FF, 1'b0, '0);
    // R11: conflicting requests during busy cycles must be ignored
    doWrite(11'h123, {4{32'hDEAD_BEEF}}, 1'b1, 11'h456, {4{32'h1111_2222}});
    doRead(11'h456, 1'b0, '0);
    doRead(11'h123, 1'b1, 11'h789);
    doRead(11'h789, 1'b0, '0);
    doRead(11'h123, 1'b0, '0);

    // constrained random traffic over a small address pool
    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int sel = $urandom % 4;
      a[10:8] = 3'($urandom % NB);
      a[7:0]  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : 8'($urandom % 4);
      d = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 2) doWrite(a, d, ($urandom % 4) == 0, 11'($urandom), ~d);
      else doRead(a, ($urandom % 4) == 0, 11'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule